// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a small bank of programmable row boundary registers into a host address map for up to eight DRAM rows. Each row's boundary register is cumulative: it holds the host address, in units of a fixed row granule, at which that row ends. An extension register holds the upper boundary bits for two rows, one nibble per row. From these the block derives a host base, a host size and a validity flag for every row.

A host address presented on the lookup port is decoded combinationally. The port reports whether a row claims the address as internal DRAM, and which row does. It also gives a translated DRAM address, built from the offset into the row's host window, masked by the row's physical size and added to that row's physical base. Any address in the legacy window from 0xA0000 up to 1 MiB, and any address that no valid row covers, is reported as external.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset, every boundary register (index 0 to NUM_ROWS-1) reads back DEF_BND and every extension register (index 8 to 8+ceil(NUM_ROWS/2)-1) reads back zero.
- R2: A register write takes effect on the next rising clock edge and reads back unmasked. Any other index reads zero, and writing to it changes nothing.
- R3: A row's effective boundary is {extension nibble, boundary byte}, keeping only the low BND_BITS bits. The extension nibble comes from extension register 8+(row>>1): even rows use bits [3:0] and odd rows use bits [7:4].
- R4: Row 0 starts at host address 0. Row i>0 starts at the previous row's effective boundary times 2^UNIT_LOG2. A row ends just below its own effective boundary times 2^UNIT_LOG2.
- R5: A row whose effective boundary is not greater than the previous row's effective boundary has zero size and claims no address. A row whose size is all ones also claims no address.
- R6: When several valid rows cover an address, the row with the lowest index is reported.
- R7: For a claimed address, the translated address is ((addr - row host base) AND (2^PHYS_LOG2 - 1)) + row_index * 2^PHYS_LOG2. A host window larger than the physical row therefore wraps.
- R8: Addresses from 0xA0000 to 0xFFFFF are always reported external, with row 0 and translated address 0.
- R9: An address that no valid row covers is reported external, with row index 0 and translated address 0.
- R10: The lookup outputs depend combinationally on the lookup address and the current register contents. A decode change caused by a write is visible in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the register at reg_idx |
| look_addr | input | ADDR_W | Host address to decode |
| look_internal | output | 1 | High when a valid row claims look_addr |
| look_row | output | ROW_W | Index of the claiming row, 0 when external |
| look_xaddr | output | ADDR_W | Translated DRAM address, 0 when external |

## Verification
The bench puts an overlapping map in place, where rows 1 and 3 both cover 20 to 28 MiB. A design with a reversed priority would report row 3 there. One row's host window is larger than its physical row, so a missing size mask would put translated addresses past the next row's physical base. The bench also programs extension nibbles whose raw value differs from their masked value, and swaps even and odd nibble contents. A design that skipped the mask would claim 1.5 to 2.5 GiB through row 6, and a design with swapped nibbles would move the row 4/row 5 split. It also probes the edges of the 640K-1M window and a row whose boundary falls below its predecessor. A leaking hole or a negative-size row would show up there as an unexpected internal hit.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
  // Index of the first extension register in the register space
  localparam int unsigned EXT_IDX0 = 8;
  // Legacy window that is never decoded as DRAM
  localparam logic [31:0] HOLE_LO = 32'h000A_0000;
  localparam logic [31:0] HOLE_HI = 32'h0010_0000;
endpackage

// File: rtl/dram_row_regs.sv
module dram_row_regs
  import dram_row_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  parameter logic [7:0]  DEF_BND  = 8'd8,
  localparam int unsigned EXT_N   = (NUM_ROWS + 1) / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [3:0]               idx,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NUM_ROWS-1:0][7:0] bnd_q,
  output logic [EXT_N-1:0][7:0]    ext_q
);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (!rst_n)                          bnd_q[r] <= DEF_BND;
      else if (we && idx == 4'(r))         bnd_q[r] <= wdata;
    end
  end

  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    always_ff @(posedge clk) begin
      if (!rst_n)                          ext_q[e] <= 8'h00;
      else if (we && idx == 4'(EXT_IDX0 + e)) ext_q[e] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int r = 0; r < NUM_ROWS; r++)
      if (idx == 4'(r)) rdata = bnd_q[r];
    for (int e = 0; e < EXT_N; e++)
      if (idx == 4'(EXT_IDX0 + e)) rdata = ext_q[e];
  end

endmodule

// File: rtl/dram_row_geometry.sv
module dram_row_geometry #(
  parameter int unsigned NUM_ROWS  = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BND_BITS  = 10,
  parameter int unsigned UNIT_LOG2 = 21,
  localparam int unsigned EXT_N    = (NUM_ROWS + 1) / 2
) (
  input  logic [NUM_ROWS-1:0][7:0]        bnd_q,
  input  logic [EXT_N-1:0][7:0]           ext_q,
  output logic [NUM_ROWS-1:0][BND_BITS-1:0] bnd_eff,
  output logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base,
  output logic [NUM_ROWS-1:0][ADDR_W-1:0] row_size,
  output logic [NUM_ROWS-1:0]             row_valid
);

  localparam int unsigned PROD_W = BND_BITS + UNIT_LOG2;

  // Merge low byte and the row's nibble, then keep BND_BITS bits
  function automatic logic [BND_BITS-1:0] merge_bnd(input logic [7:0] lo,
                                                    input logic [7:0] ext,
                                                    input logic       odd);
    logic [11:0] raw;
    raw = {(odd ? ext[7:4] : ext[3:0]), lo};
    return raw[BND_BITS-1:0];
  endfunction

  // Scale a boundary count to a host address
  function automatic logic [ADDR_W-1:0] to_host(input logic [BND_BITS-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(b) << UNIT_LOG2;
    return ADDR_W'(p);
  endfunction

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign bnd_eff[r] = merge_bnd(bnd_q[r], ext_q[r/2], 1'(r % 2));

    if (r == 0) begin : g_first
      assign row_base[r] = '0;
      assign row_size[r] = to_host(bnd_eff[r]);
    end else begin : g_next
      logic grows;
      assign grows       = bnd_eff[r] > bnd_eff[r-1];
      assign row_base[r] = to_host(bnd_eff[r-1]);
      assign row_size[r] = grows ? (to_host(bnd_eff[r]) - row_base[r]) : '0;
    end

    assign row_valid[r] = (row_size[r] != '0) && (row_size[r] != '1);
  end

endmodule

// File: rtl/dram_row_match.sv
module dram_row_match
  import dram_row_pkg::*;
#(
  parameter int unsigned NUM_ROWS  = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PHYS_LOG2 = 24,
  localparam int unsigned ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base,
  input  logic [NUM_ROWS-1:0][ADDR_W-1:0] row_size,
  input  logic [NUM_ROWS-1:0]             row_valid,
  output logic                            in_hole,
  output logic [NUM_ROWS-1:0]             hit_vec,
  output logic                            internal,
  output logic [ROW_W-1:0]                row,
  output logic [ADDR_W-1:0]               xaddr
);

  localparam logic [ADDR_W-1:0] PHYS_MASK = ADDR_W'((64'd1 << PHYS_LOG2) - 64'd1);

  function automatic logic [ADDR_W-1:0] phys_base(input int unsigned r);
    return ADDR_W'(64'(r) << PHYS_LOG2);
  endfunction

  function automatic logic [ADDR_W-1:0] xlate(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] hb,
                                              input int unsigned      r);
    return ((a - hb) & PHYS_MASK) + phys_base(r);
  endfunction

  assign in_hole = (64'(addr) >= 64'(HOLE_LO)) && (64'(addr) < 64'(HOLE_HI));

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_hit
    assign hit_vec[r] = row_valid[r] && !in_hole &&
                        (addr >= row_base[r]) &&
                        ((addr - row_base[r]) < row_size[r]);
  end

  // Scan from the top so the lowest hitting row is the last to assign
  always_comb begin
    internal = 1'b0;
    row      = '0;
    xaddr    = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        internal = 1'b1;
        row      = ROW_W'(r);
        xaddr    = xlate(addr, row_base[r], r);
      end
    end
  end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int unsigned NUM_ROWS  = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BND_BITS  = 10,
  parameter int unsigned UNIT_LOG2 = 21,
  parameter int unsigned PHYS_LOG2 = 24,
  parameter logic [7:0]  DEF_BND   = 8'd8,
  localparam int unsigned ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned EXT_N    = (NUM_ROWS + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_idx,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_internal,
  output logic [ROW_W-1:0]  look_row,
  output logic [ADDR_W-1:0] look_xaddr
);

  logic [NUM_ROWS-1:0][7:0]          bnd_q;
  logic [EXT_N-1:0][7:0]             ext_q;
  logic [NUM_ROWS-1:0][BND_BITS-1:0] bnd_eff;
  logic [NUM_ROWS-1:0][ADDR_W-1:0]   row_base;
  logic [NUM_ROWS-1:0][ADDR_W-1:0]   row_size;
  logic [NUM_ROWS-1:0]               row_valid;
  logic [NUM_ROWS-1:0]               hit_vec;
  logic                              in_hole;

  dram_row_regs #(
    .NUM_ROWS (NUM_ROWS),
    .DEF_BND  (DEF_BND)
  ) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .idx   (reg_idx),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .bnd_q (bnd_q),
    .ext_q (ext_q)
  );

  dram_row_geometry #(
    .NUM_ROWS  (NUM_ROWS),
    .ADDR_W    (ADDR_W),
    .BND_BITS  (BND_BITS),
    .UNIT_LOG2 (UNIT_LOG2)
  ) geom_i (
    .bnd_q     (bnd_q),
    .ext_q     (ext_q),
    .bnd_eff   (bnd_eff),
    .row_base  (row_base),
    .row_size  (row_size),
    .row_valid (row_valid)
  );

  dram_row_match #(
    .NUM_ROWS  (NUM_ROWS),
    .ADDR_W    (ADDR_W),
    .PHYS_LOG2 (PHYS_LOG2)
  ) match_i (
    .addr      (look_addr),
    .row_base  (row_base),
    .row_size  (row_size),
    .row_valid (row_valid),
    .in_hole   (in_hole),
    .hit_vec   (hit_vec),
    .internal  (look_internal),
    .row       (look_row),
    .xaddr     (look_xaddr)
  );

endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BND_BITS = 10,
  parameter logic [7:0]  DEF_BND  = 8'd8,
  localparam int unsigned ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              reg_we,
  input logic [3:0]                        reg_idx,
  input logic [7:0]                        reg_wdata,
  input logic [7:0]                        reg_rdata,
  input logic                              look_internal,
  input logic [ROW_W-1:0]                  look_row,
  input logic [ADDR_W-1:0]                 look_xaddr,
  input logic [NUM_ROWS-1:0]               hit_vec,
  input logic [NUM_ROWS-1:0]               row_valid,
  input logic [NUM_ROWS-1:0][BND_BITS-1:0] bnd_eff,
  input logic                              in_hole
);

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && (32'(reg_idx) < NUM_ROWS)) |-> (reg_rdata == DEF_BND));

  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (32'(reg_idx) < NUM_ROWS)) |=>
      ((reg_idx != $past(reg_idx)) || (reg_rdata == $past(reg_wdata))));

  // R5
  no_shrinking_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~row_valid) == '0);

  // R5
  row1_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_eff[1] <= bnd_eff[0]) |-> !hit_vec[1]);

  // R6
  lowest_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_internal |-> (hit_vec[look_row] &&
      ((hit_vec & ((NUM_ROWS'(1) << look_row) - NUM_ROWS'(1))) == '0)));

  // R8
  hole_external_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |-> !look_internal);

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !look_internal |-> ((look_xaddr == '0) && (look_row == '0) && (hit_vec == '0)));

endmodule

bind dram_row_decoder dram_row_decoder_chk #(
  .NUM_ROWS (NUM_ROWS),
  .ADDR_W   (ADDR_W),
  .BND_BITS (BND_BITS),
  .DEF_BND  (DEF_BND)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_idx       (reg_idx),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .look_internal (look_internal),
  .look_row      (look_row),
  .look_xaddr    (look_xaddr),
  .hit_vec       (hit_vec),
  .row_valid     (row_valid),
  .bnd_eff       (bnd_eff),
  .in_hole       (in_hole)
);

// File: tb/dram_row_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_row_decoder_tb_top;

  localparam int NR   = 8;
  localparam int AW   = 32;
  localparam int BB   = 10;
  localparam int UL   = 21;
  localparam int PL   = 24;
  localparam logic [7:0] DEFB = 8'd8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_idx = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] look_addr = '0;
  logic          look_internal;
  logic [2:0]    look_row;
  logic [AW-1:0] look_xaddr;

  always #2.5 clk = ~clk;

  dram_row_decoder #(
    .NUM_ROWS(NR), .ADDR_W(AW), .BND_BITS(BB),
    .UNIT_LOG2(UL), .PHYS_LOG2(PL), .DEF_BND(DEFB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .look_addr(look_addr),
    .look_internal(look_internal), .look_row(look_row), .look_xaddr(look_xaddr)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          hit;
    logic [2:0]    row;
    logic [AW-1:0] xa;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // Shadow of the register contents the bench believes it wrote
  logic [7:0] sh_bnd[NR];
  logic [7:0] sh_ext[NR/2];

  // Reference decode written from the requirement text
  function automatic exp_t model(input logic [AW-1:0] a, input string tag);
    exp_t e;
    longint unsigned lim[NR];
    longint unsigned lo, hi;
    e.addr = a; e.hit = 0; e.row = 0; e.xa = 0; e.tag = tag;
    for (int r = 0; r < NR; r++) begin
      int nib;
      nib = (r % 2 == 1) ? int'(sh_ext[r/2] >> 4) : int'(sh_ext[r/2] & 8'h0F);
      lim[r] = longint'((nib * 256 + int'(sh_bnd[r])) % (1 << BB)) * (64'd1 << UL);
    end
    if (a >= 32'hA0000 && a < 32'h100000) return e;            // R8
    for (int r = 0; r < NR && !e.hit; r++) begin                // R6 lowest first
      lo = (r == 0) ? 0 : lim[r-1];                             // R4
      hi = lim[r];
      if (hi > lo && longint'(a) >= lo && longint'(a) < hi) begin  // R5
        e.hit = 1;
        e.row = 3'(r);
        e.xa  = AW'(((longint'(a) - lo) % (64'd1 << PL)) + longint'(r) * (64'd1 << PL)); // R7
      end
    end
    return e;
  endfunction

  task automatic look(input logic [AW-1:0] a, input string tag);
    @(posedge clk); #1;
    look_addr = a;
    exp_q.push_back(model(a, tag));
  endtask

  // Monitor: compare at the falling edge, away from the sampling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (look_internal !== e.hit || look_row !== e.row || look_xaddr !== e.xa) begin
          errors++;
          $display("FAIL %s addr=%h: got int=%0b row=%0d x=%h, expected int=%0b row=%0d x=%h",
                   e.tag, e.addr, look_internal, look_row, look_xaddr, e.hit, e.row, e.xa);
        end
      end
    end
  end

  task automatic wr(input int idx, input logic [7:0] v);
    @(posedge clk); #1;
    reg_we = 1; reg_idx = 4'(idx); reg_wdata = v;
    @(posedge clk); #1;
    reg_we = 0;
    if (idx < NR) sh_bnd[idx] = v;
    else if (idx >= 8 && idx < 8 + NR/2) sh_ext[idx-8] = v;
  endtask

  task automatic rd(input int idx, input logic [7:0] expv, input string tag);
    @(posedge clk); #1;
    reg_idx = 4'(idx);
    @(negedge clk);
    checks++;
    if (reg_rdata !== expv) begin
      errors++;
      $display("FAIL %s reg %0d: got %h expected %h", tag, idx, reg_rdata, expv);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) sh_bnd[r] = DEFB;
    for (int e = 0; e < NR/2; e++) sh_ext[e] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset contents
    for (int r = 0; r < NR; r++) rd(r, DEFB, "R1 boundary default");
    for (int e = 8; e < 8 + NR/2; e++) rd(e, 8'h00, "R1 extension default");
    rd(12, 8'h00, "R2 unmapped read");

    // Reset map: row 0 covers 0..16 MiB, the rest is external
    look(32'h0000_0100, "R4 row0 low");
    look(32'h0009_FFFF, "R8 below hole");
    look(32'h000A_0000, "R8 hole start");
    look(32'h000F_FFFF, "R8 hole end");
    look(32'h0010_0000, "R8 above hole");
    look(32'h00FF_FFFF, "R4 row0 top");
    look(32'h0100_0000, "R9 above default");
    look(32'h8000_0000, "R9 far");

    // Program an overlapping, wrapping map
    wr(0, 8'd4);      // row0 ends 8 MiB
    wr(1, 8'd14);     // row1 8..28 MiB, host larger than physical
    wr(2, 8'd10);     // row2 shrinks: decodes nothing
    wr(3, 8'd16);     // row3 20..32 MiB, overlaps row1
    wr(4, 8'd0);
    wr(5, 8'd0);
    wr(10, 8'h32);    // R3 row4 nibble 2 (low), row5 nibble 3 (high)
    wr(6, 8'd0);
    wr(7, 8'h20);
    wr(13, 8'h55);    // R2 ignored index
    rd(13, 8'h00, "R2 ignored write");
    rd(1, 8'd14, "R2 readback");
    rd(10, 8'h32, "R2 extension readback");
    wr(11, 8'h05);    // R3 row6 nibble 5 masks to 0x100
    look(32'h6FFF_FFF0, "R10 first cycle after write");
    rd(11, 8'h05, "R2 unmasked readback");

    look(32'h0000_0100, "R4 row0");
    look(32'h007F_FFFF, "R4 row0 last");
    look(32'h0080_0000, "R4 row1 first");
    look(32'h0180_0020, "R7 row1 wrap");
    look(32'h0160_0000, "R6 row1 over row3");
    look(32'h01D0_0000, "R5 row3 only");
    look(32'h0140_0000, "R5 row2 empty");
    look(32'h0400_0000, "R3 row4");
    look(32'h4000_0010, "R3 row5 first");
    look(32'h5FFF_FFFF, "R3 row5 last");
    look(32'h6000_0000, "R9 after row5");
    look(32'h7000_0000, "R3 masked row6");
    look(32'h000C_0000, "R8 hole in map");
    for (int k = 0; k < 40; k++)
      look(AW'(k) * 32'h0113_5A37, "R7 sweep");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule